// File: doc/BRIEF.md
# Byte-Lane Inversion Codec

This block sits on one lane of a parallel bus whose lines are terminated to the high supply, so that every line driving low draws current. On the transmit side it counts the zero bits of the word about to be driven. When more than half of them are zero, it sends the complement and asserts an extra active-low flag line. The flag acts as one more data line, and the pattern on all lines together never has more than half the data width driving low. On the receive side it reads the flag and complements the word back when the flag is low.

Both halves have one register stage. Each has its own valid strobe, and a beat without valid leaves the registered outputs untouched. Which direction a given instance serves is set by where it is placed: the controller's transmit half encodes writes, and its receive half decodes reads. The width is a parameter. The default of 8 covers a data byte, and another width serves an address group that carries its own flag. A `codec_on` input turns the inversion off. In that state the flag stays high and the words pass through unchanged.

Top module: `inv_lane_codec`

## Requirements
- R1: During and straight after reset, `enc_data` is all ones, `enc_flag_n` is 1, `enc_valid` and `dec_valid` are 0, and `dec_data` is all zeros.
- R2: With `codec_on`=1, a word with more than W/2 zero bits is registered complemented, with `enc_flag_n`=0.
- R3: With `codec_on`=1, a word with W/2 or fewer zero bits is registered unchanged, with `enc_flag_n`=1. A word with exactly W/2 zeros is never inverted.
- R4: After every encoded beat with `codec_on`=1, at most W/2 of the W+1 lines {`enc_flag_n`, `enc_data`} are low.
- R5: The decoder registers `dec_word` unchanged when `dec_flag_n`=1 and complemented when `dec_flag_n`=0 (with `codec_on`=1).
- R6: Feeding the encoder output into the decoder returns the original word for every one of the 2^W values.
- R7: Each half has one cycle of latency. `enc_valid` and `dec_valid` repeat the corresponding input strobe one cycle later, and the data is that of the strobed beat.
- R8: A cycle with `src_valid`=0 leaves `enc_data` and `enc_flag_n` unchanged. A cycle with `dec_in_valid`=0 leaves `dec_data` unchanged.
- R9: With `codec_on`=0, the encoder passes the word unchanged with `enc_flag_n`=1, and the decoder passes the word unchanged whatever the level of `dec_flag_n`.
- R10: The all-zero word is sent as all ones with `enc_flag_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| codec_on | input | 1 | 1 enables inversion; 0 passes words straight through |
| src_valid | input | 1 | Encoder input strobe |
| src_word | input | W | Word to be encoded |
| enc_valid | output | 1 | Encoder output strobe |
| enc_data | output | W | Lines driven onto the bus |
| enc_flag_n | output | 1 | Active-low inversion flag driven with `enc_data` |
| dec_in_valid | input | 1 | Decoder input strobe |
| dec_word | input | W | Word received from the bus |
| dec_flag_n | input | 1 | Received active-low inversion flag |
| dec_valid | output | 1 | Decoder output strobe |
| dec_data | output | W | Restored word |

## Verification
The threshold word with exactly four zeros is the sharpest case. A comparison written as "at least" instead of "more than" would invert it and push five lines low. The all-zero and all-one words check both ends of the count. A zero counter that is one bit too narrow would wrap on all zeros and leave eight lines low. Idle beats are driven with changing input data, so a register that loads without its strobe would show up at once. Bypass is exercised with the flag held low at the decoder, which catches a decoder that still honours the flag while inversion is off.

// File: rtl/inv_lane_codec.sv
module inv_lane_codec #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         codec_on,
  input  logic         src_valid,
  input  logic [W-1:0] src_word,
  output logic         enc_valid,
  output logic [W-1:0] enc_data,
  output logic         enc_flag_n,
  input  logic         dec_in_valid,
  input  logic [W-1:0] dec_word,
  input  logic         dec_flag_n,
  output logic         dec_valid,
  output logic [W-1:0] dec_data
);
  localparam int CW   = $clog2(W + 1);
  localparam int HALF = W / 2;

  logic [CW-1:0] zeros;
  logic          flip;

  always_comb begin
    zeros = '0;
    for (int i = 0; i < W; i++)
      zeros = zeros + CW'(!src_word[i]);
  end

  assign flip = codec_on && (zeros > CW'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_valid  <= 1'b0;
      enc_data   <= '1;
      enc_flag_n <= 1'b1;
    end else begin
      enc_valid <= src_valid;
      if (src_valid) begin
        enc_data   <= flip ? ~src_word : src_word;
        enc_flag_n <= !flip;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_data  <= '0;
    end else begin
      dec_valid <= dec_in_valid;
      if (dec_in_valid)
        dec_data <= (codec_on && !dec_flag_n) ? ~dec_word : dec_word;
    end
  end
endmodule

module inv_lane_codec_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         codec_on,
  input logic         src_valid,
  input logic [W-1:0] src_word,
  input logic         enc_valid,
  input logic [W-1:0] enc_data,
  input logic         enc_flag_n,
  input logic         dec_in_valid,
  input logic [W-1:0] dec_word,
  input logic         dec_flag_n,
  input logic         dec_valid,
  input logic [W-1:0] dec_data
);
  a_r4_low_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && codec_on) |=> ($countones(~{enc_flag_n, enc_data}) <= W / 2));

  a_r7_enc_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |=> enc_valid);

  a_r7_dec_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_in_valid |=> !dec_valid);

  a_r8_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> ($stable(enc_data) && $stable(enc_flag_n)));

  a_r8_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_in_valid |=> $stable(dec_data));

  a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && !codec_on) |=> (enc_flag_n && enc_data == $past(src_word)));

  a_r10_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && codec_on && src_word == '0) |=> (!enc_flag_n && enc_data == '1));
endmodule

bind inv_lane_codec inv_lane_codec_chk #(.W(W)) u_chk (.*);

// File: tb/test_inv_lane_codec.sv
module test_inv_lane_codec;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         codec_on = 1'b1;
  logic         src_valid = 1'b0;
  logic [W-1:0] src_word = '0;
  logic         enc_valid;
  logic [W-1:0] enc_data;
  logic         enc_flag_n;
  logic         dec_in_valid = 1'b0;
  logic [W-1:0] dec_word = '0;
  logic         dec_flag_n = 1'b1;
  logic         dec_valid;
  logic [W-1:0] dec_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  inv_lane_codec #(.W(W)) i_inv_lane_codec (.*);

  function automatic int zcount(logic [W-1:0] d);
    int n = 0;
    for (int i = 0; i < W; i++) if (!d[i]) n++;
    return n;
  endfunction

  function automatic logic exp_flip(logic [W-1:0] d, logic on);
    return on && (zcount(d) > W / 2);
  endfunction

  task automatic chk(bit ok, string req, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(logic [W-1:0] d, logic on, string req);
    logic f;
    logic [W-1:0] ed;
    @(negedge clk);
    codec_on = on; src_word = d; src_valid = 1'b1; dec_in_valid = 1'b0;
    @(negedge clk);
    src_valid = 1'b0;
    src_word  = ~d;
    f  = exp_flip(d, on);
    ed = f ? ~d : d;
    chk(enc_valid && enc_data == ed && enc_flag_n == !f, req,
        {enc_flag_n, enc_data}, {!f, ed});
    if (on)
      chk($countones(~{enc_flag_n, enc_data}) <= W / 2, "R4",
          {enc_flag_n, enc_data}, {1'b1, ed});
    dec_word = enc_data; dec_flag_n = enc_flag_n; dec_in_valid = 1'b1;
    @(negedge clk);
    dec_in_valid = 1'b0;
    chk(dec_valid && dec_data == d, "R6", {1'b0, dec_data}, {1'b0, d});
  endtask

  task automatic dec_only(logic [W-1:0] w, logic fl, logic on, string req);
    logic [W-1:0] e;
    @(negedge clk);
    codec_on = on; dec_word = w; dec_flag_n = fl; dec_in_valid = 1'b1;
    @(negedge clk);
    dec_in_valid = 1'b0;
    e = (on && !fl) ? ~w : w;
    chk(dec_valid && dec_data == e, req, {1'b0, dec_data}, {1'b0, e});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    logic hf;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(enc_data == '1 && enc_flag_n && !enc_valid && !dec_valid && dec_data == '0,
        "R1", {enc_flag_n, enc_data}, {1'b1, {W{1'b1}}});
    rst_n = 1'b1;
    @(negedge clk);
    chk(enc_data == '1 && enc_flag_n && !enc_valid, "R1",
        {enc_flag_n, enc_data}, {1'b1, {W{1'b1}}});

    beat('0, 1'b1, "R10");
    beat('1, 1'b1, "R3");
    beat(8'h0F, 1'b1, "R3");
    beat(8'h55, 1'b1, "R3");
    beat(8'h07, 1'b1, "R2");
    beat(8'h80, 1'b1, "R2");

    for (int v = 0; v < 256; v++)
      beat(W'(v), 1'b1, (zcount(W'(v)) > W / 2) ? "R2" : "R3");

    for (int k = 0; k < 200; k++)
      beat(W'($urandom), 1'b1, "R7");

    beat(8'h01, 1'b1, "R2");
    held = enc_data; hf = enc_flag_n;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      src_word = W'($urandom); src_valid = 1'b0;
      dec_word = W'($urandom); dec_flag_n = k[0]; dec_in_valid = 1'b0;
    end
    @(negedge clk);
    chk(enc_data == held && enc_flag_n == hf && !enc_valid, "R8",
        {enc_flag_n, enc_data}, {hf, held});
    chk(dec_data == 8'h01 && !dec_valid, "R8", {1'b0, dec_data}, {1'b0, 8'h01});

    beat('0, 1'b0, "R9");
    for (int k = 0; k < 40; k++)
      beat(W'($urandom), 1'b0, "R9");
    dec_only(8'h3C, 1'b0, 1'b0, "R9");

    dec_only(8'hA5, 1'b0, 1'b1, "R5");
    dec_only(8'hA5, 1'b1, 1'b1, "R5");
    for (int k = 0; k < 30; k++)
      dec_only(W'($urandom), 1'($urandom), 1'b1, "R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule